// File: doc/BRIEF.md
# Two-Thread Register Rename Map with Branch Checkpoints

This block translates architectural register numbers into physical register tags for a core that runs two hardware threads. Each thread has its own live map. Both threads draw new destination tags from one shared pool of physical registers. One instruction is renamed per cycle. It names a thread, two source registers and an optional destination register. In the same cycle the block returns the source tags, a freshly allocated destination tag, and the tag that the destination held before.

An instruction flagged as a branch stores a copy of its thread's map, including its own destination write, in a per-thread circular ring of checkpoints. The ring slot is reported to the caller. A resolve port either restores a checkpoint on a misprediction, which also drops every younger checkpoint, or drops the oldest checkpoint when the prediction was right. A release port returns superseded tags to the pool. A tag that any live checkpoint still names is parked until the last such checkpoint is gone, and only then is it returned.

Top module: `rr_rename_map`

## Requirements
- R1: After reset, thread t maps architectural register a to physical tag t*16+a, and tags 32 to 63 are free.
- R2: An accepted rename with the destination enable set allocates the lowest-numbered free tag on ren_pdst_o. In the same cycle it reports the destination's prior tag on ren_pold_o, and it writes the new tag into the thread's map.
- R3: Source tags are read combinationally from the thread's current map. A source equal to the same instruction's destination returns the prior tag, and a write made by the rename accepted in the previous cycle is visible.
- R4: The two threads keep independent maps but allocate from the same pool.
- R5: A renamed branch stores its thread's map with its own destination write applied. ren_snap_o gives the slot, and slots are handed out in order 0,1,2,3 and then wrap to 0 for each thread.
- R6: A resolve with res_miss_i=1 and slot k copies slot k into the live map and discards slot k and all younger slots, so the thread's next branch again receives slot k.
- R7: A resolve with res_miss_i=0 discards the thread's oldest slot and leaves the live map unchanged.
- R8: A released tag that no live checkpoint names can be allocated from the second cycle after the release cycle.
- R9: A released tag that a live checkpoint names is not allocated until that checkpoint is discarded. It can be allocated from the second cycle after the discarding resolve.
- R10: ren_ready_o is low while the free pool is empty.
- R11: ren_ready_o is low for a branch whose thread already holds 4 live checkpoints. The other thread is not affected.
- R12: ren_ready_o is low for a rename on a thread whose misprediction is presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 1 | Rename request present |
| ren_tid_i | input | 1 | Thread of the request |
| ren_src0_i | input | 4 | First source architectural register |
| ren_src1_i | input | 4 | Second source architectural register |
| ren_dst_we_i | input | 1 | Request writes a destination |
| ren_dst_i | input | 4 | Destination architectural register |
| ren_branch_i | input | 1 | Request is an unresolved branch needing a checkpoint |
| ren_ready_o | output | 1 | Request accepted this cycle when valid |
| ren_psrc0_o | output | 6 | Physical tag of first source |
| ren_psrc1_o | output | 6 | Physical tag of second source |
| ren_pdst_o | output | 6 | Newly allocated destination tag |
| ren_pold_o | output | 6 | Destination's prior tag |
| ren_snap_o | output | 2 | Checkpoint slot given to a branch |
| res_valid_i | input | 1 | Branch resolution present |
| res_tid_i | input | 1 | Thread of the resolution |
| res_miss_i | input | 1 | 1 for misprediction, 0 for correct |
| res_snap_i | input | 2 | Slot of the mispredicted branch |
| rel_valid_i | input | 1 | Tag release present |
| rel_tag_i | input | 6 | Superseded tag being released |

## Verification
All rename results are combinational, so source, destination, prior tag, slot and ready are sampled in the request's own cycle, at the falling edge before the accepting rising edge. Map writes and restores take effect for the next cycle's request. A released tag passes through a pending register and then the free register, so it is expected from the second cycle after its release or after its discarding resolve. The bench also checks the intervening cycle for the older allocation. Each scenario starts from reset, which makes every expected tag a fixed number derived from lowest-first allocation.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int unsigned RR_THREADS = 2;
  localparam int unsigned RR_AREGS   = 16;
  localparam int unsigned RR_PREGS   = 64;
  localparam int unsigned RR_SNAPS   = 4;
endpackage

// File: rtl/rr_free_pool.sv
module rr_free_pool #(
  parameter int unsigned NP  = rr_pkg::RR_PREGS,
  parameter int unsigned RSV = 32,
  localparam int unsigned PW = $clog2(NP)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  output logic [PW-1:0] alloc_tag_o,
  output logic          any_free_o,
  input  logic          rel_i,
  input  logic [PW-1:0] rel_tag_i,
  input  logic [NP-1:0] refd_i,
  output logic [NP-1:0] free_o
);
  logic [NP-1:0] free_q, pend_q, free_d, pend_d;

  always_comb begin
    alloc_tag_o = '0;
    any_free_o  = 1'b0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (free_q[i]) begin
        alloc_tag_o = PW'(i);
        any_free_o  = 1'b1;
      end
    end
  end

  // released tags wait in pend until no live checkpoint names them
  always_comb begin
    free_d = free_q | (pend_q & ~refd_i);
    if (alloc_i) free_d[alloc_tag_o] = 1'b0;
    pend_d = pend_q & refd_i;
    if (rel_i) pend_d[rel_tag_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NP; i++) free_q[i] <= (i >= RSV);
      pend_q <= '0;
    end else begin
      free_q <= free_d;
      pend_q <= pend_d;
    end
  end

  assign free_o = free_q;
endmodule

// File: rtl/rr_thread_map.sv
module rr_thread_map #(
  parameter int unsigned NA   = rr_pkg::RR_AREGS,
  parameter int unsigned NP   = rr_pkg::RR_PREGS,
  parameter int unsigned NS   = rr_pkg::RR_SNAPS,
  parameter int unsigned BASE = 0,
  localparam int unsigned AW  = $clog2(NA),
  localparam int unsigned PW  = $clog2(NP),
  localparam int unsigned SW  = $clog2(NS),
  localparam int unsigned CW  = $clog2(NS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd0_i,
  input  logic [AW-1:0] rd1_i,
  input  logic [AW-1:0] wr_i,
  input  logic          we_i,
  input  logic [PW-1:0] wtag_i,
  input  logic          take_i,
  input  logic          commit_i,
  input  logic          squash_i,
  input  logic [SW-1:0] squash_idx_i,
  output logic [PW-1:0] rd0_o,
  output logic [PW-1:0] rd1_o,
  output logic [PW-1:0] old_o,
  output logic          full_o,
  output logic [SW-1:0] tail_o,
  output logic [NP-1:0] refd_o
);
  logic [PW-1:0] map_q   [NA];
  logic [PW-1:0] map_upd [NA];
  logic [PW-1:0] snap_q  [NS][NA];
  logic [SW-1:0] head_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] kof;

  assign tail_o = head_q + SW'(cnt_q);
  assign full_o = (cnt_q == CW'(NS));
  assign kof    = squash_idx_i - head_q;
  assign rd0_o  = map_q[rd0_i];
  assign rd1_o  = map_q[rd1_i];
  assign old_o  = map_q[wr_i];

  always_comb begin
    map_upd = map_q;
    if (we_i) map_upd[wr_i] = wtag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < NA; a++) map_q[a] <= PW'(BASE + a);
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (squash_i) begin
        map_q <= snap_q[squash_idx_i];
        cnt_q <= CW'(kof);
      end else begin
        map_q <= map_upd;
        cnt_q <= cnt_q + CW'(take_i) - CW'(commit_i && cnt_q != '0);
        if (commit_i && cnt_q != '0) head_q <= head_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (take_i) snap_q[tail_o] <= map_upd;
  end

  always_comb begin
    refd_o = '0;
    for (int s = 0; s < NS; s++) begin
      if (CW'(SW'(s) - head_q) < cnt_q) begin
        for (int a = 0; a < NA; a++) refd_o[snap_q[s][a]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rr_rename_map.sv
module rr_rename_map #(
  parameter int unsigned NUM_THREADS = rr_pkg::RR_THREADS,
  parameter int unsigned NUM_AREGS   = rr_pkg::RR_AREGS,
  parameter int unsigned NUM_PREGS   = rr_pkg::RR_PREGS,
  parameter int unsigned NUM_SNAPS   = rr_pkg::RR_SNAPS,
  localparam int unsigned TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int unsigned AW = $clog2(NUM_AREGS),
  localparam int unsigned PW = $clog2(NUM_PREGS),
  localparam int unsigned SW = $clog2(NUM_SNAPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ren_valid_i,
  input  logic [TW-1:0] ren_tid_i,
  input  logic [AW-1:0] ren_src0_i,
  input  logic [AW-1:0] ren_src1_i,
  input  logic          ren_dst_we_i,
  input  logic [AW-1:0] ren_dst_i,
  input  logic          ren_branch_i,
  output logic          ren_ready_o,
  output logic [PW-1:0] ren_psrc0_o,
  output logic [PW-1:0] ren_psrc1_o,
  output logic [PW-1:0] ren_pdst_o,
  output logic [PW-1:0] ren_pold_o,
  output logic [SW-1:0] ren_snap_o,
  input  logic          res_valid_i,
  input  logic [TW-1:0] res_tid_i,
  input  logic          res_miss_i,
  input  logic [SW-1:0] res_snap_i,
  input  logic          rel_valid_i,
  input  logic [PW-1:0] rel_tag_i
);
  logic [PW-1:0] rd0_t [NUM_THREADS];
  logic [PW-1:0] rd1_t [NUM_THREADS];
  logic [PW-1:0] old_t [NUM_THREADS];
  logic [SW-1:0] tail_t [NUM_THREADS];
  logic [NUM_PREGS-1:0] refd_t [NUM_THREADS];
  logic [NUM_THREADS-1:0] full_t;
  logic [NUM_PREGS-1:0] refd_all, free_vec;
  logic [PW-1:0] alloc_tag;
  logic any_free, fire, alloc, squash_hit;

  assign squash_hit  = res_valid_i && res_miss_i && (res_tid_i == ren_tid_i);
  assign ren_ready_o = any_free && !(ren_branch_i && full_t[ren_tid_i]) && !squash_hit;
  assign fire        = ren_valid_i && ren_ready_o;
  assign alloc       = fire && ren_dst_we_i;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    rr_thread_map #(
      .NA(NUM_AREGS), .NP(NUM_PREGS), .NS(NUM_SNAPS), .BASE(t * NUM_AREGS)
    ) u_map (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rd0_i       (ren_src0_i),
      .rd1_i       (ren_src1_i),
      .wr_i        (ren_dst_i),
      .we_i        (alloc && ren_tid_i == TW'(t)),
      .wtag_i      (alloc_tag),
      .take_i      (fire && ren_branch_i && ren_tid_i == TW'(t)),
      .commit_i    (res_valid_i && !res_miss_i && res_tid_i == TW'(t)),
      .squash_i    (res_valid_i && res_miss_i && res_tid_i == TW'(t)),
      .squash_idx_i(res_snap_i),
      .rd0_o       (rd0_t[t]),
      .rd1_o       (rd1_t[t]),
      .old_o       (old_t[t]),
      .full_o      (full_t[t]),
      .tail_o      (tail_t[t]),
      .refd_o      (refd_t[t])
    );
  end

  always_comb begin
    refd_all = '0;
    for (int t = 0; t < NUM_THREADS; t++) refd_all = refd_all | refd_t[t];
  end

  rr_free_pool #(.NP(NUM_PREGS), .RSV(NUM_THREADS * NUM_AREGS)) u_pool (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_i    (alloc),
    .alloc_tag_o(alloc_tag),
    .any_free_o (any_free),
    .rel_i      (rel_valid_i),
    .rel_tag_i  (rel_tag_i),
    .refd_i     (refd_all),
    .free_o     (free_vec)
  );

  assign ren_psrc0_o = rd0_t[ren_tid_i];
  assign ren_psrc1_o = rd1_t[ren_tid_i];
  assign ren_pold_o  = old_t[ren_tid_i];
  assign ren_pdst_o  = alloc_tag;
  assign ren_snap_o  = tail_t[ren_tid_i];
endmodule

// File: rtl/rr_rename_map_chk.sv
module rr_rename_map_chk #(
  parameter int unsigned NP = 64,
  localparam int unsigned PW = $clog2(NP)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          ready_i,
  input logic          we_i,
  input logic [PW-1:0] pdst_i,
  input logic [PW-1:0] pold_i,
  input logic [NP-1:0] free_i,
  input logic [NP-1:0] refd_i
);
  assert_alloc_from_pool_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_i && we_i) |-> free_i[pdst_i]);

  assert_alloc_leaves_pool_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_i && we_i) |=> !free_i[$past(pdst_i)]);

  assert_new_differs_old_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_i && we_i) |-> (pdst_i != pold_i));

  assert_no_free_while_snapped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_i & refd_i) == '0);

  assert_stall_on_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && free_i == '0) |-> !ready_i);
endmodule

bind rr_rename_map rr_rename_map_chk #(.NP(NUM_PREGS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(ren_valid_i),
  .ready_i(ren_ready_o),
  .we_i   (ren_dst_we_i),
  .pdst_i (ren_pdst_o),
  .pold_i (ren_pold_o),
  .free_i (free_vec),
  .refd_i (refd_all)
);

// File: tb/rr_rename_map_tb.sv
module rr_rename_map_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic ren_valid_i = 0, ren_tid_i = 0, ren_dst_we_i = 0, ren_branch_i = 0;
  logic [3:0] ren_src0_i = 0, ren_src1_i = 0, ren_dst_i = 0;
  logic ren_ready_o;
  logic [5:0] ren_psrc0_o, ren_psrc1_o, ren_pdst_o, ren_pold_o;
  logic [1:0] ren_snap_o;
  logic res_valid_i = 0, res_tid_i = 0, res_miss_i = 0;
  logic [1:0] res_snap_i = 0;
  logic rel_valid_i = 0;
  logic [5:0] rel_tag_i = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rr_rename_map u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ren_valid_i(ren_valid_i), .ren_tid_i(ren_tid_i), .ren_src0_i(ren_src0_i),
    .ren_src1_i(ren_src1_i), .ren_dst_we_i(ren_dst_we_i), .ren_dst_i(ren_dst_i),
    .ren_branch_i(ren_branch_i), .ren_ready_o(ren_ready_o),
    .ren_psrc0_o(ren_psrc0_o), .ren_psrc1_o(ren_psrc1_o), .ren_pdst_o(ren_pdst_o),
    .ren_pold_o(ren_pold_o), .ren_snap_o(ren_snap_o),
    .res_valid_i(res_valid_i), .res_tid_i(res_tid_i), .res_miss_i(res_miss_i),
    .res_snap_i(res_snap_i), .rel_valid_i(rel_valid_i), .rel_tag_i(rel_tag_i)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_in;
    ren_valid_i = 0; ren_tid_i = 0; ren_dst_we_i = 0; ren_branch_i = 0;
    ren_src0_i = 0; ren_src1_i = 0; ren_dst_i = 0;
    res_valid_i = 0; res_tid_i = 0; res_miss_i = 0; res_snap_i = 0;
    rel_valid_i = 0; rel_tag_i = 0;
  endtask

  // inputs change just after a rising edge; outputs are sampled at the falling edge
  task automatic adv;
    @(posedge clk); #1; idle_in();
  endtask

  task automatic settle;
    @(negedge clk);
  endtask

  task automatic put(bit tid, int s0, int s1, bit we, int d, bit br);
    ren_valid_i = 1; ren_tid_i = tid; ren_src0_i = 4'(s0); ren_src1_i = 4'(s1);
    ren_dst_we_i = we; ren_dst_i = 4'(d); ren_branch_i = br;
  endtask

  task automatic do_reset;
    idle_in();
    rst_ni = 0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1;
  endtask

  task automatic t_reset_map;
    do_reset();
    put(1, 0, 15, 0, 0, 0); settle();
    chk("R1 t1 a0", ren_psrc0_o, 16);
    chk("R1 t1 a15", ren_psrc1_o, 31);
    chk("R1 ready", ren_ready_o, 1);
    adv();
    put(0, 9, 0, 1, 9, 0); settle();
    chk("R1 t0 a9", ren_psrc0_o, 9);
    chk("R1 first free", ren_pdst_o, 32);
    adv();
  endtask

  task automatic t_basic;
    do_reset();
    put(0, 3, 5, 1, 3, 0); settle();
    chk("R3 src same as dst", ren_psrc0_o, 3);
    chk("R3 src1", ren_psrc1_o, 5);
    chk("R2 pdst", ren_pdst_o, 32);
    chk("R2 pold", ren_pold_o, 3);
    adv();
    put(0, 3, 0, 0, 0, 0); settle();
    chk("R3 next cycle", ren_psrc0_o, 32);
    adv();
    put(1, 3, 0, 1, 3, 0); settle();
    chk("R4 other thread map", ren_psrc0_o, 19);
    chk("R4 shared pool", ren_pdst_o, 33);
    chk("R4 pold", ren_pold_o, 19);
    adv();
  endtask

  task automatic t_mispredict;
    do_reset();
    put(0, 0, 0, 1, 4, 1); settle();
    chk("R5 branch pdst", ren_pdst_o, 32);
    chk("R5 slot0", ren_snap_o, 0);
    adv();
    put(0, 0, 0, 1, 4, 0); settle();
    chk("R2 pold after branch", ren_pold_o, 32);
    adv();
    put(0, 0, 0, 0, 0, 1); settle();
    chk("R5 slot1", ren_snap_o, 1);
    adv();
    put(0, 0, 0, 1, 4, 0); settle();
    chk("R2 pdst 34", ren_pdst_o, 34);
    adv();
    put(0, 4, 0, 0, 0, 0);
    res_valid_i = 1; res_tid_i = 0; res_miss_i = 1; res_snap_i = 0;
    settle();
    chk("R12 stall on same-thread restore", ren_ready_o, 0);
    adv();
    put(0, 4, 0, 0, 0, 1); settle();
    chk("R6 restored map", ren_psrc0_o, 32);
    chk("R6 slot reused", ren_snap_o, 0);
    adv();
  endtask

  task automatic t_full;
    do_reset();
    put(1, 0, 0, 1, 2, 1); settle();
    chk("R5 t1 slot0", ren_snap_o, 0);
    adv();
    for (int i = 1; i < 4; i++) begin
      put(1, 0, 0, 0, 0, 1); settle();
      chk("R5 t1 slot seq", ren_snap_o, i);
      adv();
    end
    put(1, 0, 0, 0, 0, 1); settle();
    chk("R11 full stall", ren_ready_o, 0);
    adv();
    put(0, 0, 0, 0, 0, 1); settle();
    chk("R11 other thread ok", ren_ready_o, 1);
    chk("R11 other slot", ren_snap_o, 0);
    adv();
    res_valid_i = 1; res_tid_i = 1; res_miss_i = 0;
    adv();
    put(1, 2, 0, 0, 0, 1); settle();
    chk("R7 ready after discard", ren_ready_o, 1);
    chk("R7 map unchanged", ren_psrc0_o, 32);
    chk("R5 wrap slot", ren_snap_o, 0);
    adv();
  endtask

  task automatic t_empty;
    do_reset();
    for (int i = 0; i < 32; i++) begin
      put(0, 0, 0, 1, i % 16, 0); settle();
      chk("R2 ascending alloc", ren_pdst_o, 32 + i);
      adv();
    end
    put(0, 0, 0, 1, 1, 0);
    rel_valid_i = 1; rel_tag_i = 5;
    settle();
    chk("R10 empty stall", ren_ready_o, 0);
    adv();
    put(0, 0, 0, 1, 1, 0); settle();
    chk("R8 not yet free", ren_ready_o, 0);
    adv();
    put(0, 0, 0, 1, 1, 0); settle();
    chk("R8 ready", ren_ready_o, 1);
    chk("R8 reused tag", ren_pdst_o, 5);
    adv();
  endtask

  task automatic t_pending;
    do_reset();
    put(0, 0, 0, 1, 7, 0); settle();
    chk("R2 pdst", ren_pdst_o, 32);
    adv();
    put(0, 0, 0, 0, 0, 1); settle();
    adv();
    put(0, 0, 0, 1, 7, 0); settle();
    chk("R2 pold 32", ren_pold_o, 32);
    adv();
    rel_valid_i = 1; rel_tag_i = 32;
    adv();
    adv();
    adv();
    put(0, 0, 0, 1, 1, 0); settle();
    chk("R9 held while snapped", ren_pdst_o, 34);
    adv();
    res_valid_i = 1; res_tid_i = 0; res_miss_i = 0;
    adv();
    put(0, 0, 0, 1, 1, 0); settle();
    chk("R9 one cycle after discard", ren_pdst_o, 35);
    adv();
    put(0, 0, 0, 1, 1, 0); settle();
    chk("R9 freed after discard", ren_pdst_o, 32);
    adv();
  endtask

  task automatic run_all;
    t_reset_map();
    t_basic();
    t_mispredict();
    t_full();
    t_empty();
    t_pending();
  endtask

  initial begin
    fork
      run_all();
      begin
        #4000000;
        checks++; errors++;
        $display("FAIL watchdog all-R actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule